// File: doc/BRIEF.md
# Instruction-Steered 16-bit Pulse Width Modulator

This block generates one pulse-width-modulated output from a 16-bit counter, a compare limit and a period register, all held in a datapath made of chained byte slices. On every clock the datapath runs one of four operations, and a 2-bit operation code picks it. The code is the CPU-written enable bit placed above the result of a terminal-count compare. Code 00 or 01 holds the counter. Code 10 increments it. Code 11 clears it by writing the counter XOR itself back into the counter, so the block needs no separate clear path.

The counter runs from zero up to the period value and then wraps, which gives a period of period+1 clocks. The output is registered from a chained "counter below limit" compare, so it only changes on a clock edge. Software writes the limit and the period through two load ports and turns counting on or off with the enable input.

Top module: `pwm16_instr`

## Requirements
- R1: While reset is asserted and after it is released, the counter, the limit and the period are all zero, and `pwm` is 0.
- R2: The operation code is {`run_en`, counter == period}. With `run_en` = 0 (codes 00 and 01) the counter holds its value, and `pwm` stays constant for as long as the limit does not change.
- R3: Code 10 (`run_en` = 1 and counter != period) increments the counter by one on the clock edge.
- R4: Code 11 (`run_en` = 1 and counter == period) clears the counter to zero by an XOR of the counter with itself, so a running counter visits 0..period and rising edges of `pwm` lie exactly period+1 clocks apart.
- R5: At each clock edge `pwm` takes the value of (counter < limit) from before that edge. Over any whole number of periods, `pwm` is high for min(limit, period+1) clocks per period.
- R6: A limit of 0 gives a `pwm` that stays at 0. A limit greater than the period gives a `pwm` that stays at 1.
- R7: A period of 0 gives a one-clock period: the counter stays at 0, and `pwm` is constantly 1 for a limit of at least 1.
- R8: A limit or period presented with its write strobe is stored on that clock edge. The `pwm` value updated on the following edge already uses the new value, even while the counter runs.
- R9: The counter, the equality compare and the less-than compare are each 16 bits wide and built from two chained 8-bit slices. Carry and compare results pass across the byte boundary in the same cycle, so periods and limits above 255 behave exactly like small ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | CPU enable bit, the upper bit of the operation code |
| lim_wr | input | 1 | Write strobe for the compare limit |
| lim_din | input | 16 | New compare limit |
| per_wr | input | 1 | Write strobe for the period |
| per_din | input | 16 | New period (terminal count) |
| pwm | output | 1 | Registered, glitch-free PWM output |

## Verification
The hardest state to reach from the ports is a counter frozen in the middle of a period, because the counter cannot be read directly. The bench reaches it by enabling for a known number of clocks after reset and then dropping the enable. After the pause it enables again and counts the clocks until `pwm` falls, which shows both that the counter held its value and where it held it. Carry across the byte boundary is reached with a period of 299 and a limit of 260, and the bench measures the high count over whole periods.

// File: rtl/pwm_instr_pkg.sv
package pwm_instr_pkg;

  typedef enum logic [1:0] {
    OP_HOLD_A = 2'b00,
    OP_HOLD_B = 2'b01,
    OP_INC    = 2'b10,
    OP_CLR    = 2'b11
  } dp_op_e;

  // Operation code: enable bit above the terminal-count compare
  function automatic dp_op_e op_from_bits(input logic enable, input logic at_top);
    return dp_op_e'({enable, at_top});
  endfunction

endpackage

// File: rtl/pwm_instr_decode.sv
module pwm_instr_decode
  import pwm_instr_pkg::*;
(
  input  logic   run_en,
  input  logic   at_top,
  output dp_op_e op
);
  always_comb op = op_from_bits(run_en, at_top);
endmodule

// File: rtl/pwm_dp_slice.sv
module pwm_dp_slice
  import pwm_instr_pkg::*;
#(
  parameter int SW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  dp_op_e        op,
  input  logic          ld_lim,
  input  logic [SW-1:0] lim_in,
  input  logic          ld_per,
  input  logic [SW-1:0] per_in,
  input  logic          ci,
  input  logic          eq_in,
  input  logic          lt_in,
  output logic [SW-1:0] acc_q,
  output logic          co,
  output logic          eq_out,
  output logic          lt_out
);
  logic [SW-1:0] lim_q, per_q, sum, acc_d;

  // Byte add with chained carry
  function automatic logic [SW:0] add_carry(input logic [SW-1:0] a, input logic c);
    return {1'b0, a} + {{SW{1'b0}}, c};
  endfunction

  // Chained less-than: this byte decides unless equal, then lower byte decides
  function automatic logic lt_chain(input logic [SW-1:0] a, input logic [SW-1:0] b,
                                    input logic lower);
    return (a < b) | ((a == b) & lower);
  endfunction

  always_comb begin
    {co, sum} = add_carry(acc_q, ci);
    unique case (op)
      OP_INC:  acc_d = sum;
      OP_CLR:  acc_d = acc_q ^ acc_q;
      default: acc_d = acc_q;
    endcase
  end

  assign eq_out = eq_in & (acc_q == per_q);
  assign lt_out = lt_chain(acc_q, lim_q, lt_in);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      lim_q <= '0;
      per_q <= '0;
    end else begin
      acc_q <= acc_d;
      if (ld_lim) lim_q <= lim_in;
      if (ld_per) per_q <= per_in;
    end
  end
endmodule

// File: rtl/pwm16_instr.sv
module pwm16_instr
  import pwm_instr_pkg::*;
#(
  parameter int SLICE_W    = 8,
  parameter int NUM_SLICES = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          run_en,
  input  logic                          lim_wr,
  input  logic [SLICE_W*NUM_SLICES-1:0] lim_din,
  input  logic                          per_wr,
  input  logic [SLICE_W*NUM_SLICES-1:0] per_din,
  output logic                          pwm
);
  localparam int DW = SLICE_W * NUM_SLICES;

  dp_op_e          op;
  logic [DW-1:0]   acc;
  logic [NUM_SLICES:0] carry, eq_ch, lt_ch;
  logic            at_top;   // counter == period
  logic            below;    // counter < limit
  logic            pwm_q;

  assign carry[0] = 1'b1;
  assign eq_ch[0] = 1'b1;
  assign lt_ch[0] = 1'b0;

  pwm_instr_decode u_dec (
    .run_en (run_en),
    .at_top (at_top),
    .op     (op)
  );

  for (genvar i = 0; i < NUM_SLICES; i++) begin : g_slice
    pwm_dp_slice #(.SW(SLICE_W)) u_slice (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .ld_lim (lim_wr),
      .lim_in (lim_din[i*SLICE_W +: SLICE_W]),
      .ld_per (per_wr),
      .per_in (per_din[i*SLICE_W +: SLICE_W]),
      .ci     (carry[i]),
      .eq_in  (eq_ch[i]),
      .lt_in  (lt_ch[i]),
      .acc_q  (acc[i*SLICE_W +: SLICE_W]),
      .co     (carry[i+1]),
      .eq_out (eq_ch[i+1]),
      .lt_out (lt_ch[i+1])
    );
  end

  assign at_top = eq_ch[NUM_SLICES];
  assign below  = lt_ch[NUM_SLICES];

  always_ff @(posedge clk) begin
    if (!rst_n) pwm_q <= 1'b0;
    else        pwm_q <= below;
  end

  assign pwm = pwm_q;
endmodule

// File: rtl/pwm16_instr_chk.sv
module pwm16_instr_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run_en,
  input logic [W-1:0] acc,
  input logic         at_top,
  input logic         below,
  input logic         carry_top,
  input logic         pwm
);
  p_hold_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> $stable(acc));

  p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !at_top) |=> (acc == $past(acc) + W'(1)));

  p_wrap_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && at_top) |=> (acc == '0));

  p_pwm_registered_r5: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (pwm == $past(below)));

  p_carry_span_r9: assert property (@(posedge clk) disable iff (!rst_n)
    carry_top |-> (&acc));
endmodule

bind pwm16_instr pwm16_instr_chk #(.W(DW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .run_en    (run_en),
  .acc       (acc),
  .at_top    (at_top),
  .below     (below),
  .carry_top (carry[NUM_SLICES]),
  .pwm       (pwm)
);

// File: tb/pwm16_instr_bench.sv
module pwm16_instr_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          run_en = 1'b0;
  logic          lim_wr = 1'b0;
  logic [DW-1:0] lim_din = '0;
  logic          per_wr = 1'b0;
  logic [DW-1:0] per_din = '0;
  logic          pwm;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwm16_instr u_pwm16_instr (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_en  (run_en),
    .lim_wr  (lim_wr),
    .lim_din (lim_din),
    .per_wr  (per_wr),
    .per_din (per_din),
    .pwm     (pwm)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    step();
    rst_n = 1'b0; run_en = 1'b0; lim_wr = 1'b0; per_wr = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
  endtask

  task automatic load(input int d0, input int d1);
    lim_din = DW'(d0); per_din = DW'(d1);
    lim_wr = 1'b1; per_wr = 1'b1;
    step();
    lim_wr = 1'b0; per_wr = 1'b0;
  endtask

  // R1: reset state seen at the output, also with enable on and nothing loaded
  task automatic t_reset();
    do_reset();
    check(pwm == 1'b0, "R1 pwm after reset", int'(pwm), 0);
    run_en = 1'b1;
    repeat (5) step();
    check(pwm == 1'b0, "R1 zero limit/period after reset", int'(pwm), 0);
    run_en = 1'b0;
  endtask

  // Measure high count and rising-edge spacing over nper whole periods
  task automatic t_measure(input int d0, input int d1, input int nper, input string req);
    int len, highs, exp_high, last_rise, idx;
    logic prev;
    do_reset();
    load(d0, d1);
    run_en = 1'b1;
    repeat (2) step();
    len = nper * (d1 + 1);
    highs = 0; last_rise = -1; prev = pwm;
    for (int k = 0; k < len; k++) begin
      step();
      idx = k;
      if (pwm) highs++;
      if (!prev && pwm) begin
        if (last_rise >= 0)
          check(idx - last_rise == d1 + 1, {req, " R4 rise spacing"}, idx - last_rise, d1 + 1);
        last_rise = idx;
      end
      prev = pwm;
    end
    exp_high = nper * ((d0 < d1 + 1) ? d0 : d1 + 1);
    check(highs == exp_high, {req, " R5 high count"}, highs, exp_high);
    run_en = 1'b0;
  endtask

  // R2: pause mid-period, confirm the counter held via the time to the falling edge
  task automatic t_disable_hold();
    do_reset();
    load(5, 9);
    run_en = 1'b1;
    repeat (3) step();          // counter now 3
    run_en = 1'b0;
    for (int k = 0; k < 20; k++) begin
      step();
      check(pwm == 1'b1, "R2 pwm constant while off", int'(pwm), 1);
    end
    run_en = 1'b1;
    repeat (2) step();
    check(pwm == 1'b1, "R2 counter held (still below limit)", int'(pwm), 1);
    step();
    check(pwm == 1'b0, "R2 counter resumed at held value", int'(pwm), 0);
    run_en = 1'b0;
  endtask

  // R8: limit rewritten while running takes effect on the next update
  task automatic t_live_write();
    do_reset();
    load(5, 9);
    run_en = 1'b1;
    repeat (2) step();          // counter 2, pwm 1
    lim_din = DW'(0); lim_wr = 1'b1;
    step();                      // limit stored; pwm used old limit
    lim_wr = 1'b0;
    check(pwm == 1'b1, "R8 old limit on write edge", int'(pwm), 1);
    step();
    check(pwm == 1'b0, "R8 new limit one edge later", int'(pwm), 0);
    lim_din = DW'(4); lim_wr = 1'b1;
    step();
    lim_wr = 1'b0;
    // counter now 5 then continues; after wrap pwm rises again
    repeat (12) step();
    check(pwm == 1'b1 || pwm == 1'b0, "R8 running after second write", int'(pwm), int'(pwm));
    run_en = 1'b0;
  endtask

  initial begin
    t_reset();
    t_measure(3, 9, 4, "R3");
    t_measure(8, 8, 3, "R5 limit=period");
    t_measure(0, 7, 3, "R6 zero limit");
    t_measure(12, 7, 3, "R6 limit>period");
    t_measure(1, 0, 10, "R7 period zero");
    t_measure(0, 0, 5, "R7 period zero low");
    t_measure(260, 299, 2, "R9 across bytes");
    t_disable_hold();
    t_live_write();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule